// File: doc/BRIEF.md
# Four-Function Nibble ALU with Status Flags

This block is a purely combinational arithmetic logic unit for 4-bit operands. Two operands and a 2-bit operation select go in. The block returns a 4-bit result and a 4-bit status word. The operations are add, subtract, bitwise AND and bitwise OR. The status word reports whether the result is zero, whether it is negative, the carry out, and signed overflow.

The result bits are the same whether the operands are read as unsigned or as two's-complement numbers. The negative and overflow flags use the two's-complement reading. Subtraction adds the inverted second operand plus one. Its carry therefore means "no borrow". The block has no clock, no state and no carry input. A datapath around it registers its inputs and outputs as it needs.

Top module: `nibble_alu`

## Requirements
- R1: With `op_sel` = 2'b00 the result is (`opa` + `opb`) modulo 16.
- R2: With `op_sel` = 2'b01 the result is (`opa` - `opb`) modulo 16.
- R3: With `op_sel` = 2'b10 the result is the bitwise AND of the operands, for example 0111 & 0101 = 0101.
- R4: With `op_sel` = 2'b11 the result is the bitwise OR of the operands, for example 0011 | 1000 = 1011.
- R5: The zero flag is 1 exactly when the 4-bit result is 0000, for every operation.
- R6: The negative flag equals result bit 3, for every operation.
- R7: For add, the carry flag is 1 exactly when the unsigned sum exceeds 15, for example 1100 + 1001.
- R8: For subtract, the carry flag is 1 exactly when `opa` >= `opb` unsigned, meaning no borrow.
- R9: For add, the overflow flag is 1 exactly when the signed sum lies outside -8..7, for example 0111 + 0001 and 1000 + 1110.
- R10: For subtract, the overflow flag is 1 exactly when the signed difference lies outside -8..7.
- R11: For AND and OR, the carry and overflow flags are 0.
- R12: The status word is packed as bit 3 = overflow, bit 2 = carry, bit 1 = negative, bit 0 = zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | 4 | Operation result |
| status | output | 4 | {overflow, carry, negative, zero} |

## Verification
The immediate assertions are re-evaluated whenever an input changes. They check that:
- the add sum and the subtract difference match plain integer arithmetic;
- the subtract carry tracks the unsigned comparison;
- the subtract overflow follows the sign rule;
- the bitwise results are consistent with their operands;
- the logic operations never raise carry or overflow;
- a raised zero or negative flag agrees with the result.

The add overflow against the signed range and the packing order of the status word can only be shown by the bench. It sweeps every operand pair under every opcode and compares against values computed from signed and unsigned integer arithmetic.

// File: rtl/nibble_alu_pkg.sv
package nibble_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  // Packed so that the status port reads {ovf, carry, neg, zero}
  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } alu_status_t;

endpackage

// File: rtl/nibble_alu_addsub.sv
module nibble_alu_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] wide_add(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin
  );
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  // Signed overflow: same-sign addends, result sign differs
  function automatic logic sign_break(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide_sum;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign wide_sum = wide_add(a_i, b_eff, sub_i);
  assign sum_o    = wide_sum[MSB:0];
  assign carry_o  = wide_sum[WIDTH];
  assign ovf_o    = sign_break(a_i[MSB], b_eff[MSB], sum_o[MSB]);

  always_comb begin
    if (!sub_i) begin
      AST_ADD_CARRY: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i})) else $error("add carry"); // R7
    end
    if (sub_i) begin
      AST_SUB_DIFF: assert (sum_o == a_i - b_i) else $error("sub diff"); // R2
      AST_SUB_NO_BORROW: assert (carry_o == (a_i >= b_i)) else $error("sub carry"); // R8
      AST_SUB_OVERFLOW: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (sum_o[MSB] != a_i[MSB]))) else $error("sub ovf"); // R10
    end
  end

endmodule

// File: rtl/nibble_alu_bitwise.sv
module nibble_alu_bitwise #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             or_sel_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;

  assign and_w = a_i & b_i;
  assign or_w  = a_i | b_i;
  assign y_o   = or_sel_i ? or_w : and_w;

  always_comb begin
    if (or_sel_i) begin
      AST_OR_COVERS: assert (((y_o & a_i) == a_i) && ((y_o & b_i) == b_i)) else $error("or cover"); // R4
    end else begin
      AST_AND_SUBSET: assert (((y_o | a_i) == a_i) && ((y_o | b_i) == b_i)) else $error("and subset"); // R3
    end
  end

endmodule

// File: rtl/nibble_alu_flags.sv
module nibble_alu_flags
  import nibble_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  output alu_status_t      status_o
);
  localparam int MSB = WIDTH - 1;

  assign status_o.zero  = ~|res_i;
  assign status_o.neg   = res_i[MSB];
  assign status_o.carry = arith_i & carry_i;
  assign status_o.ovf   = arith_i & ovf_i;

  always_comb begin
    if (!arith_i) begin
      AST_LOGIC_NO_CARRY: assert (!status_o.carry && !status_o.ovf) else $error("logic flags"); // R11
    end
    if (status_o.zero) begin
      AST_ZERO_FLAG: assert (res_i == '0) else $error("zero flag"); // R5
    end
    if (status_o.neg) begin
      AST_NEG_FLAG: assert ($signed(res_i) < 0) else $error("neg flag"); // R6
    end
  end

endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibble_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       status
);
  alu_op_e          op;
  logic             is_arith;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_carry;
  logic             arith_ovf;
  alu_status_t      flags;

  assign op       = alu_op_e'(op_sel);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  nibble_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i     (opa),
    .b_i     (opb),
    .sub_i   (op == OP_SUB),
    .sum_o   (arith_res),
    .carry_o (arith_carry),
    .ovf_o   (arith_ovf)
  );

  nibble_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i      (opa),
    .b_i      (opb),
    .or_sel_i (op == OP_OR),
    .y_o      (logic_res)
  );

  assign result = is_arith ? arith_res : logic_res;

  nibble_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i    (result),
    .arith_i  (is_arith),
    .carry_i  (arith_carry),
    .ovf_i    (arith_ovf),
    .status_o (flags)
  );

  assign status = flags;

  always_comb begin
    if (op == OP_ADD) begin
      AST_ADD_SUM: assert (result == opa + opb) else $error("add sum"); // R1
    end
  end

endmodule

// File: tb/nibble_alu_bench.sv
module nibble_alu_bench;
  logic       clk = 1'b0;
  logic [3:0] opa = '0;
  logic [3:0] opb = '0;
  logic [1:0] op_sel = '0;
  logic [3:0] result;
  logic [3:0] status;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nibble_alu u_nibble_alu (
    .opa    (opa),
    .opb    (opb),
    .op_sel (op_sel),
    .result (result),
    .status (status)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", tag, op_sel, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input int op, input int a, input int b);
    @(negedge clk);
    op_sel = 2'(op);
    opa    = 4'(a);
    opb    = 4'(b);
    #1;
  endtask

  task automatic sweep_one(input int op, input int a, input int b);
    int sa, sb, sv, er, ec, eo, ez, en;
    sa = (a > 7) ? a - 16 : a;
    sb = (b > 7) ? b - 16 : b;
    ec = 0; eo = 0;
    case (op)
      0: begin er = (a + b) % 16; ec = int'(a + b > 15); sv = sa + sb; eo = int'(sv > 7 || sv < -8); end
      1: begin er = (a - b + 16) % 16; ec = int'(a >= b); sv = sa - sb; eo = int'(sv > 7 || sv < -8); end
      2: er = a & b;
      default: er = a | b;
    endcase
    ez = int'(er == 0);
    en = int'(er >= 8);
    apply(op, a, b);
    case (op)
      0: check("R1 add result", int'(result), er);
      1: check("R2 sub result", int'(result), er);
      2: check("R3 and result", int'(result), er);
      default: check("R4 or result", int'(result), er);
    endcase
    check("R5 zero", int'(status[0]), ez);
    check("R6 negative", int'(status[1]), en);
    if (op == 0)      check("R7 add carry", int'(status[2]), ec);
    else if (op == 1) check("R8 sub carry", int'(status[2]), ec);
    else              check("R11 logic carry", int'(status[2]), 0);
    if (op == 0)      check("R9 add overflow", int'(status[3]), eo);
    else if (op == 1) check("R10 sub overflow", int'(status[3]), eo);
    else              check("R11 logic overflow", int'(status[3]), 0);
    check("R12 status packing", int'(status), eo * 8 + ec * 4 + en * 2 + ez);
  endtask

  initial begin
    // Idle inputs (add 0+0): result 0, only zero flag
    #1;
    check("R5 idle result", int'(result), 0);
    check("R12 idle status", int'(status), 1);
    // Named corner cases
    apply(0, 12, 9);  check("R7 1100+1001 carry", int'(status[2]), 1);
    apply(0, 7, 1);   check("R9 0111+0001 ovf", int'(status[3]), 1);
    check("R6 0111+0001 neg", int'(status[1]), 1);
    apply(0, 8, 14);  check("R9 1000+1110 ovf", int'(status[3]), 1);
    check("R1 1000+1110 result", int'(result), 6);
    apply(3, 3, 8);   check("R4 0011|1000", int'(result), 11);
    apply(2, 7, 5);   check("R3 0111&0101", int'(result), 5);
    apply(1, 5, 5);   check("R8 equal sub carry", int'(status[2]), 1);
    check("R5 equal sub zero", int'(status[0]), 1);
    apply(1, 8, 1);   check("R10 -8-1 ovf", int'(status[3]), 1);
    apply(1, 0, 1);   check("R8 0-1 borrow", int'(status[2]), 0);
    // Exhaustive sweep
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          sweep_one(op, a, b);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule